// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer whose countdown runs on its own slow clock, separate from the bus clock used to program it. Every control action goes through a single key register. Software writes one magic value to start the countdown, another to refresh it, and a further pair to open and close write access to the configuration. Once the countdown has started, nothing software writes can halt it. If the count is allowed to run out, the block raises a reset request for one watchdog-clock cycle. It then reloads and keeps counting.

There are two configuration registers: a 3-bit divide code and a 12-bit reload value. Each one has a bus-side copy, and that copy crosses into the watchdog clock domain through a toggle handshake. While a transfer is in flight, its busy flag is set, and the bus discards any further writes to that register. Refresh commands cross the domain through the same kind of handshake, and a refresh that arrives while the previous one is still in flight is merged with it. The register port is a plain single-cycle write strobe and a combinational read mux, with no back-pressure. The watchdog-side count, the running flag and the reset request leave the block as plain pins.

Top module: `key_watchdog`

## Requirements
- R1: After reset, the divide code reads 0, the reload reads 0xFFF, status reads 0, `cfg_ready` is 1, the watchdog is not running, `wdg_count` is 0xFFF, and no reset request occurs.
- R2: Writing 0xCCCC to the key register (address 0) starts the countdown. No other key value starts it, a refresh key sent before start included. Once running, the countdown stays running whatever key is written later.
- R3: Writing 0xAAAA to the key register reloads the count from the reload value and restarts the current division period. Refreshes spaced more closely than the timeout prevent any reset request.
- R4: Writing 0x5555 to the key register opens configuration writes, and writing 0x0000 closes them. A write to the divide register (address 1) or the reload register (address 2) while closed is discarded.
- R5: A key value other than 0xCCCC, 0xAAAA, 0x5555 and 0x0000 has no effect, and the open or closed state of configuration writes stays as it was.
- R6: Divide code c selects a ratio of 4·2^c for c from 0 to 6, and code 7 behaves as code 6 (a ratio of 256). While running, reset requests repeat every (reload+1)·ratio watchdog-clock cycles.
- R7: A divide write keeps only bits [2:0], and a reload write keeps only bits [11:0]. All other data bits are ignored.
- R8: Status (address 3) bit 0 flags a divide-code transfer in flight, and bit 1 flags a reload transfer in flight. A flag is set in the cycle after its write is accepted and clears after the handshake round trip. `cfg_ready` is 1 only when both flags are 0.
- R9: A write to the divide or reload register while that register's busy flag is set is discarded.
- R10: `wdg_rst_req` is high for exactly one watchdog-clock cycle per expiry, and only while the countdown is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | 2 | Write address: 0 key, 1 divide code, 2 reload, 3 status |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address (same map) |
| rd_data | output | 16 | Combinational read data; the key register reads 0 |
| cfg_ready | output | 1 | Both configuration transfers idle |
| wdg_clk | input | 1 | Watchdog low-speed clock |
| wdg_rst_n | input | 1 | Watchdog-domain asynchronous reset, active low |
| wdg_running | output | 1 | Countdown started (watchdog domain) |
| wdg_count | output | 12 | Current down-counter value (watchdog domain) |
| wdg_rst_req | output | 1 | One-cycle reset request on expiry (watchdog domain) |

## Verification
The bench builds the block with its default parameters: 16-bit data, a 12-bit reload, a 3-bit divide code and two synchroniser stages. It drives the watchdog clock at a quarter of the bus rate with a fixed phase offset, so handshake latencies are repeatable. Because software can program short reload values, the expiry period can be measured for every one of the eight divide codes against several reload values, and each period is compared with (reload+1)·ratio. The lock, masking, stray-key and busy-drop rules are checked through register read-back.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  localparam logic [15:0] KEY_START  = 16'hCCCC;
  localparam logic [15:0] KEY_RELOAD = 16'hAAAA;
  localparam logic [15:0] KEY_OPEN   = 16'h5555;
  localparam logic [15:0] KEY_CLOSE  = 16'h0000;

  // highest divide code with its own ratio; larger codes clamp to it
  localparam int PRESC_MAX_CODE = 6;

  typedef enum logic [1:0] {
    SEL_KEY    = 2'd0,
    SEL_PRESC  = 2'd1,
    SEL_RELOAD = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/kwd_sync.sv
module kwd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/kwd_xfer.sv
module kwd_xfer #(
  parameter int            W         = 8,
  parameter logic [W-1:0]  RESET_VAL = '0,
  parameter int            STAGES    = 2
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic         src_wr,
  input  logic [W-1:0] src_data,
  output logic         src_busy,
  output logic [W-1:0] src_value,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dst_value
);

  logic         req_t, ack_s, req_s, seen_q;
  logic [W-1:0] shadow_q, dst_q;

  // source side: shadow copy plus request toggle
  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      shadow_q <= RESET_VAL;
      req_t    <= 1'b0;
    end else if (src_wr) begin
      shadow_q <= src_data;
      req_t    <= ~req_t;
    end
  end

  kwd_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(dst_clk), .rst_n(dst_rst_n), .d(req_t), .q(req_s)
  );

  // destination side: capture the held shadow when the toggle lands
  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      seen_q <= 1'b0;
      dst_q  <= RESET_VAL;
    end else begin
      seen_q <= req_s;
      if (req_s != seen_q) dst_q <= shadow_q;
    end
  end

  kwd_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(src_clk), .rst_n(src_rst_n), .d(seen_q), .q(ack_s)
  );

  assign src_busy  = req_t ^ ack_s;
  assign src_value = shadow_q;
  assign dst_value = dst_q;

  AST_BUSY_AFTER_WRITE: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_wr |=> src_busy); // R8
  AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_busy |-> !src_wr); // R9
  AST_IDLE_COHERENT: assert property (@(posedge src_clk) disable iff (!src_rst_n || !dst_rst_n)
    !src_busy |-> (dst_value == src_value)); // R8

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
  import kwd_pkg::*;
#(
  parameter int RLD_W = 12,
  parameter int PR_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             refresh_par,
  input  logic [PR_W-1:0]  code,
  input  logic [RLD_W-1:0] reload,
  output logic [RLD_W-1:0] count,
  output logic             running,
  output logic             rst_req
);

  localparam int PRE_W = PRESC_MAX_CODE + 2;

  logic [PR_W-1:0]  code_c;
  logic [PRE_W:0]   div_m1;
  logic [PRE_W-1:0] pre_q;
  logic [RLD_W-1:0] cnt_q;
  logic             run_q, req_q, par_q, refresh, tick;

  assign code_c  = (code > PR_W'(PRESC_MAX_CODE)) ? PR_W'(PRESC_MAX_CODE) : code;
  assign div_m1  = ((PRE_W+1)'(4) << code_c) - 1'b1;
  assign tick    = ({1'b0, pre_q} >= div_m1);
  assign refresh = (refresh_par != par_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '1;
      pre_q <= '0;
      req_q <= 1'b0;
      par_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      par_q <= refresh_par;
      if (!run_q) begin
        if (start) begin
          run_q <= 1'b1;
          cnt_q <= reload;
          pre_q <= '0;
        end
      end else if (refresh) begin
        cnt_q <= reload;
        pre_q <= '0;
      end else if (tick) begin
        pre_q <= '0;
        if (cnt_q == '0) begin
          req_q <= 1'b1;
          cnt_q <= reload;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign count   = cnt_q;
  assign running = run_q;
  assign rst_req = req_q;

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R10
  AST_REQ_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> running); // R10
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running); // R2
  AST_REFRESH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (running && refresh_par != $past(refresh_par)) |=> (count == $past(reload))); // R3

endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
  import kwd_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int RLD_W       = 12,
  parameter int PR_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              cfg_ready,
  input  logic              wdg_clk,
  input  logic              wdg_rst_n,
  output logic              wdg_running,
  output logic [RLD_W-1:0]  wdg_count,
  output logic              wdg_rst_req
);

  localparam logic [RLD_W-1:0] RLD_RESET = '1;

  reg_sel_e wsel, rsel;
  logic key_wr, is_start, is_reload, is_open, is_close;
  logic open_q, started_q, start_s;
  logic pr_wr, rl_wr, rf_wr;
  logic pr_busy, rl_busy, rf_busy;
  logic [PR_W-1:0]  pr_val, pr_dst;
  logic [RLD_W-1:0] rl_val, rl_dst;
  logic             rf_par, rf_dst;

  assign wsel      = reg_sel_e'(wr_addr);
  assign rsel      = reg_sel_e'(rd_addr);
  assign key_wr    = wr_en && (wsel == SEL_KEY);
  assign is_start  = key_wr && (wr_data == DATA_W'(KEY_START));
  assign is_reload = key_wr && (wr_data == DATA_W'(KEY_RELOAD));
  assign is_open   = key_wr && (wr_data == DATA_W'(KEY_OPEN));
  assign is_close  = key_wr && (wr_data == DATA_W'(KEY_CLOSE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      started_q <= 1'b0;
    end else begin
      if (is_open)       open_q <= 1'b1;
      else if (is_close) open_q <= 1'b0;
      if (is_start) started_q <= 1'b1;
    end
  end

  assign pr_wr = wr_en && (wsel == SEL_PRESC)  && open_q && !pr_busy;
  assign rl_wr = wr_en && (wsel == SEL_RELOAD) && open_q && !rl_busy;
  assign rf_wr = is_reload && !rf_busy;

  kwd_xfer #(.W(PR_W), .RESET_VAL('0), .STAGES(SYNC_STAGES)) u_pr_xfer (
    .src_clk(clk), .src_rst_n(rst_n), .src_wr(pr_wr), .src_data(wr_data[PR_W-1:0]),
    .src_busy(pr_busy), .src_value(pr_val),
    .dst_clk(wdg_clk), .dst_rst_n(wdg_rst_n), .dst_value(pr_dst)
  );

  kwd_xfer #(.W(RLD_W), .RESET_VAL(RLD_RESET), .STAGES(SYNC_STAGES)) u_rl_xfer (
    .src_clk(clk), .src_rst_n(rst_n), .src_wr(rl_wr), .src_data(wr_data[RLD_W-1:0]),
    .src_busy(rl_busy), .src_value(rl_val),
    .dst_clk(wdg_clk), .dst_rst_n(wdg_rst_n), .dst_value(rl_dst)
  );

  // refresh travels as a parity flip; a pending one absorbs later ones
  kwd_xfer #(.W(1), .RESET_VAL(1'b0), .STAGES(SYNC_STAGES)) u_rf_xfer (
    .src_clk(clk), .src_rst_n(rst_n), .src_wr(rf_wr), .src_data(~rf_par),
    .src_busy(rf_busy), .src_value(rf_par),
    .dst_clk(wdg_clk), .dst_rst_n(wdg_rst_n), .dst_value(rf_dst)
  );

  kwd_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
    .clk(wdg_clk), .rst_n(wdg_rst_n), .d(started_q), .q(start_s)
  );

  kwd_counter #(.RLD_W(RLD_W), .PR_W(PR_W)) u_counter (
    .clk(wdg_clk), .rst_n(wdg_rst_n), .start(start_s), .refresh_par(rf_dst),
    .code(pr_dst), .reload(rl_dst),
    .count(wdg_count), .running(wdg_running), .rst_req(wdg_rst_req)
  );

  always_comb begin
    unique case (rsel)
      SEL_KEY:    rd_data = '0;
      SEL_PRESC:  rd_data = DATA_W'(pr_val);
      SEL_RELOAD: rd_data = DATA_W'(rl_val);
      SEL_STATUS: rd_data = DATA_W'({rl_busy, pr_busy});
    endcase
  end

  assign cfg_ready = !pr_busy && !rl_busy;

  AST_CLOSED_PRESC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wsel == SEL_PRESC && !open_q) |=> $stable(pr_val)); // R4
  AST_CLOSED_RELOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wsel == SEL_RELOAD && !open_q) |=> $stable(rl_val)); // R4
  AST_BUSY_DROPS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wsel == SEL_RELOAD && rl_busy) |=> $stable(rl_val)); // R9
  AST_STRAY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !is_start && !is_reload && !is_open && !is_close) |=> $stable(open_q)); // R5
  AST_START_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |=> started_q); // R2

endmodule

// File: tb/key_watchdog_tb.sv
module key_watchdog_tb;

  logic        clk = 1'b0, wdg_clk = 1'b0;
  logic        rst_n = 1'b0, wdg_rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        cfg_ready, wdg_running, wdg_rst_req;
  logic [11:0] wdg_count;

  int tests = 0, fails = 0, pulse_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;
  initial begin
    #2;
    forever #16 wdg_clk = ~wdg_clk;
  end

  key_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cfg_ready(cfg_ready),
    .wdg_clk(wdg_clk), .wdg_rst_n(wdg_rst_n), .wdg_running(wdg_running),
    .wdg_count(wdg_count), .wdg_rst_req(wdg_rst_req)
  );

  always @(negedge wdg_clk) if (wdg_rst_req) pulse_cnt++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic bus_write(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr[1:0]; wr_data = data[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input int addr, output int val);
    rd_addr = addr[1:0];
    #1;
    val = int'(rd_data);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 100 && !cfg_ready; i++) @(negedge clk);
  endtask

  task automatic measure(input int code, input int rl);
    int ratio, expv, t, n;
    ratio = 4 << ((code > 6) ? 6 : code);
    expv  = (rl + 1) * ratio;
    bus_write(1, code);
    bus_write(2, rl);
    wait_ready();
    bus_write(0, 16'hAAAA);
    repeat (40) @(negedge clk);
    t = 0;
    do begin @(negedge wdg_clk); t++; end while (!wdg_rst_req && t < 5000);
    n = 0;
    do begin
      @(negedge wdg_clk); n++;
      if (n == 1) chk(!wdg_rst_req, "R10 request width", int'(wdg_rst_req), 0);
    end while (!wdg_rst_req && n < 5000);
    chk(n == expv, $sformatf("R6 period code=%0d reload=%0d", code, rl), n, expv);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v, n, p0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1; wdg_rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(1, v); chk(v == 0, "R1 divide reset", v, 0);
    bus_read(2, v); chk(v == 16'hFFF, "R1 reload reset", v, 16'hFFF);
    bus_read(3, v); chk(v == 0, "R1 status reset", v, 0);
    bus_read(0, v); chk(v == 0, "R1 key reads zero", v, 0);
    chk(cfg_ready, "R1 ready", int'(cfg_ready), 1);
    chk(!wdg_running, "R1 not running", int'(wdg_running), 0);
    chk(wdg_count == 12'hFFF, "R1 count reset", int'(wdg_count), 16'hFFF);

    // R4 closed by default
    bus_write(1, 5);
    bus_read(1, v); chk(v == 0, "R4 closed divide write dropped", v, 0);
    bus_read(3, v); chk(v == 0, "R4 closed write sets no flag", v, 0);
    bus_write(0, 16'h5555);
    bus_write(1, 5);
    bus_read(1, v); chk(v == 5, "R4 open divide write", v, 5);
    wait_ready();
    // R5 stray key keeps open state
    bus_write(0, 16'h1234);
    bus_write(2, 16'h123);
    bus_read(2, v); chk(v == 16'h123, "R5 stray key keeps open", v, 16'h123);
    wait_ready();
    bus_write(0, 16'h0000);
    bus_write(1, 2);
    bus_read(1, v); chk(v == 5, "R4 close then divide write dropped", v, 5);
    bus_write(2, 7);
    bus_read(2, v); chk(v == 16'h123, "R4 close then reload write dropped", v, 16'h123);
    bus_write(0, 16'h9999);
    bus_write(1, 2);
    bus_read(1, v); chk(v == 5, "R5 stray key keeps closed", v, 5);

    // R7 masking
    bus_write(0, 16'h5555);
    bus_write(1, 16'hFFFE);
    bus_read(1, v); chk(v == 6, "R7 divide mask", v, 6);
    bus_write(2, 16'hABCD);
    bus_read(2, v); chk(v == 16'hBCD, "R7 reload mask", v, 16'hBCD);
    wait_ready();

    // R8 busy flags and R9 drop while busy
    bus_write(1, 3);
    bus_read(3, v); chk(v == 1, "R8 divide flag only", v, 1);
    chk(!cfg_ready, "R8 ready low while busy", int'(cfg_ready), 0);
    bus_write(1, 4);
    bus_read(1, v); chk(v == 3, "R9 write while busy dropped", v, 3);
    n = 0;
    bus_read(3, v);
    while (v[0] && n < 100) begin @(negedge clk); n++; bus_read(3, v); end
    chk(n >= 4 && n <= 30, "R8 divide flag clears", n, 16);
    bus_write(2, 40);
    bus_read(3, v); chk(v == 2, "R8 reload flag only", v, 2);
    wait_ready();
    bus_read(3, v); chk(v == 0 && cfg_ready, "R8 ready after transfer", v, 0);

    // R2 refresh before start does not start
    bus_write(0, 16'hAAAA);
    repeat (40) @(negedge clk);
    chk(!wdg_running, "R2 refresh does not start", int'(wdg_running), 0);
    chk(wdg_count == 12'hFFF, "R2 count idle before start", int'(wdg_count), 16'hFFF);
    chk(pulse_cnt == 0, "R10 no request before start", pulse_cnt, 0);

    // R2 start
    bus_write(1, 0);
    bus_write(2, 20);
    wait_ready();
    bus_write(0, 16'hCCCC);
    repeat (40) @(negedge clk);
    chk(wdg_running, "R2 started", int'(wdg_running), 1);
    chk(wdg_count <= 20, "R2 counting from reload", int'(wdg_count), 20);
    bus_write(0, 16'h0000);
    bus_write(0, 16'h5555);
    bus_write(0, 16'h4321);
    repeat (40) @(negedge clk);
    chk(wdg_running, "R2 cannot stop", int'(wdg_running), 1);

    // R3 refresh
    bus_write(0, 16'hAAAA);
    repeat (40) @(negedge clk);
    chk(wdg_count >= 16 && wdg_count <= 20, "R3 refresh reloads", int'(wdg_count), 20);
    p0 = pulse_cnt;
    for (int i = 0; i < 10; i++) begin
      repeat (150) @(negedge clk);
      bus_write(0, 16'hAAAA);
    end
    chk(pulse_cnt == p0, "R3 refresh prevents request", pulse_cnt, p0);
    repeat (500) @(negedge clk);
    chk(pulse_cnt > p0, "R10 request after timeout", pulse_cnt, p0 + 1);

    // R6 sweep of every code against several reloads
    for (int c = 0; c < 8; c++) begin
      measure(c, 0);
      measure(c, 1);
      measure(c, 3);
      measure(c, 6);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule